// File: doc/BRIEF.md
# Real-Time Clock Dual Alarm Interrupt Controller

This block sits beside the timekeeping counters of a real-time clock. It holds two time-of-day alarm sets of four fields each (seconds, minutes, hours, day), a control register and a status register. Each time the counters step (one `tick_i` pulse per update), both alarm sets are compared with the current time fields. Any field whose stored bit 7 is 1 is left out of the compare. A match sets that alarm's request flag.

The control register gates flag 0 onto an active-low level interrupt and flag 1 onto an active-high pulse of `PULSE_CYC` system clock cycles. It also holds the output-enable for a 1 Hz square wave and a write-protect bit. The write-protect bit comes out of reset set, so software must clear it before any other write takes effect. Reading or writing any register of an alarm set clears that set's flag. Register access uses an 8-bit address, read and write strobes, write data and combinational read data.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the control register reads 0x40, the status register reads 0x00, `int0_no` is 1, `int1_o` is 0 and `hz_oe_o` is 0.
- R2: While the write-protect bit is 1, writes to alarm registers are rejected and leave the stored value unchanged. A control write changes only the write-protect bit, from write-data bit 6. The other control bits keep their value.
- R3: The control register is written at 0x8F and read at 0x0F. Bit 6 is write-protect, bit 2 is the 1 Hz enable, bit 1 is the alarm-1 enable and bit 0 is the alarm-0 enable. Bits 7, 5, 4 and 3 read as 0. `hz_oe_o` follows bit 2.
- R4: Alarm 0 is read at 0x07 to 0x0A and alarm 1 at 0x0B to 0x0E, in the field order seconds, minutes, hours, day. The write address of each alarm register is its read address with bit 7 set. All 8 bits of each register are stored and read back.
- R5: The compare runs only in a cycle with `tick_i` high. It matches bits 6:0 of each stored field against the 7-bit time input.
- R6: A stored field whose bit 7 is 1 is excluded from the compare. With all four masks set, every tick matches. With only the day mask set, hours, minutes and seconds must match. With only the seconds field unmasked, seconds alone must match.
- R7: The status register is read-only at 0x10. Bit 0 is the alarm-0 flag, bit 1 is the alarm-1 flag, and bits 7 to 2 read as 0. Reading it clears nothing.
- R8: A read strobe at an alarm set's read address, or a write strobe at its write address, clears that set's flag. This includes a write rejected by write-protect. The other set's flag is unaffected.
- R9: When a match and a clearing access to the same alarm set fall in the same cycle, the flag ends up set.
- R10: `int0_no` is 0 exactly while the alarm-0 flag and the alarm-0 enable are both 1.
- R11: A match of alarm 1 on a tick with the alarm-1 enable at 1 drives `int1_o` high for `PULSE_CYC` cycles, starting the cycle after the tick. Clearing the enable forces `int1_o` to 0 from the next cycle. A match with the enable at 0 still sets the flag but gives no pulse.
- R12: Writes to 0x90 or 0x10 leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address; bit 7 set for write addresses |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | One-cycle pulse per clock update |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| day_i | input | 7 | Current day, BCD |
| int0_no | output | 1 | Alarm-0 interrupt, active low, level |
| int1_o | output | 1 | Alarm-1 interrupt, active high pulse |
| hz_oe_o | output | 1 | Output enable of the 1 Hz output |

## Verification
The compare is driven with a time that differs in one field only, with a matching time held while `tick_i` stays low, and with a matching time whose inputs carry stray upper bits. These cases separate a missing field compare, an untimed compare and a compare that includes the mask bit. Three mask patterns on alarm 1 (all masked, day only, seconds only) separate per-field masking from whole-set masking. A mismatch in the seconds field under the day-only pattern shows that masking does not spread to other fields. A clearing read placed in the same cycle as a matching tick tells set-over-clear priority from the reverse. A write to the other set's registers while write-protect is on tells per-set clearing from global clearing.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 4;   // sec, min, hour, day
  localparam int NUM_ALARMS = 2;
  localparam int ALM_BASE   = 7;   // first alarm read address

  typedef logic [7:0] reg8_t;
  typedef logic [6:0] tval_t;
  typedef reg8_t [NUM_FIELDS-1:0] fields_t;
  typedef tval_t [NUM_FIELDS-1:0] tfields_t;

  localparam logic [7:0] ADDR_CTRL_RD = 8'h0F;
  localparam logic [7:0] ADDR_CTRL_WR = 8'h8F;
  localparam logic [7:0] ADDR_STAT_RD = 8'h10;

  localparam int CTRL_WP   = 6;
  localparam int CTRL_HZ   = 2;
  localparam int CTRL_AIE1 = 1;
  localparam int CTRL_AIE0 = 0;
  localparam int MASK_BIT  = 7;
endpackage

// File: rtl/rtc_alarm_set.sv
module rtc_alarm_set
  import rtc_alarm_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FIELDS-1:0] we_i,
  input  reg8_t                 wdata_i,
  input  tfields_t              time_i,
  input  logic                  tick_i,
  input  logic                  clr_i,
  output fields_t               regs_o,
  output logic                  flag_o,
  output logic                  hit_o
);
  fields_t               regs_q;
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_q[f] <= '0;
      else if (we_i[f]) regs_q[f] <= wdata_i;
    end
    assign fld_ok[f] = regs_q[f][MASK_BIT] | (regs_q[f][6:0] == time_i[f]);
  end

  assign hit_o = tick_i & (&fld_ok);

  // a new match outranks a clearing access in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit_o)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/rtc_pulse_gen.sv
module rtc_pulse_gen #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (trig_i)        cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = en_i & (cnt_q != '0);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       tick_i,
  input  logic [6:0] sec_i,
  input  logic [6:0] min_i,
  input  logic [6:0] hour_i,
  input  logic [6:0] day_i,
  output logic       int0_no,
  output logic       int1_o,
  output logic       hz_oe_o
);
  tfields_t              cur_time;
  fields_t               alm_regs [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] irq_flag;
  logic [NUM_ALARMS-1:0] alm_hit;
  logic                  wp_q, hz_q, aie1_q, aie0_q;
  logic                  ctrl_wr;

  assign cur_time = {day_i, hour_i, min_i, sec_i};
  assign ctrl_wr  = wr_i && (addr_i == ADDR_CTRL_WR);

  // while protected only the protect bit itself is writable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= 1'b1;
      hz_q   <= 1'b0;
      aie1_q <= 1'b0;
      aie0_q <= 1'b0;
    end else if (ctrl_wr) begin
      wp_q <= wdata_i[CTRL_WP];
      if (!wp_q) begin
        hz_q   <= wdata_i[CTRL_HZ];
        aie1_q <= wdata_i[CTRL_AIE1];
        aie0_q <= wdata_i[CTRL_AIE0];
      end
    end
  end

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alm
    localparam logic [6:0] BASE = 7'(ALM_BASE + k * NUM_FIELDS);
    logic [6:0]            off;
    logic                  in_win;
    logic                  acc;
    logic [NUM_FIELDS-1:0] we;

    assign off    = addr_i[6:0] - BASE;
    assign in_win = (addr_i[6:0] >= BASE) && (off < 7'(NUM_FIELDS));
    assign acc    = in_win & ((rd_i & ~addr_i[7]) | (wr_i & addr_i[7]));

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_we
      assign we[f] = wr_i & addr_i[7] & in_win & ~wp_q & (off == 7'(f));
    end

    rtc_alarm_set u_set (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .wdata_i (wdata_i),
      .time_i  (cur_time),
      .tick_i  (tick_i),
      .clr_i   (acc),
      .regs_o  (alm_regs[k]),
      .flag_o  (irq_flag[k]),
      .hit_o   (alm_hit[k])
    );
  end

  rtc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_int1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (aie1_q),
    .trig_i  (alm_hit[1]),
    .pulse_o (int1_o)
  );

  assign int0_no = ~(aie0_q & irq_flag[0]);
  assign hz_oe_o = hz_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL_RD) begin
      rdata_o[CTRL_WP]   = wp_q;
      rdata_o[CTRL_HZ]   = hz_q;
      rdata_o[CTRL_AIE1] = aie1_q;
      rdata_o[CTRL_AIE0] = aie0_q;
    end
    if (addr_i == ADDR_STAT_RD) rdata_o[NUM_ALARMS-1:0] = irq_flag;
    for (int k = 0; k < NUM_ALARMS; k++) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (addr_i == 8'(ALM_BASE + k * NUM_FIELDS + f)) rdata_o = alm_regs[k][f];
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic       tick_i,
  input logic       int0_no,
  input logic       int1_o,
  input logic       wp_q,
  input logic       hz_q,
  input logic       aie1_q,
  input logic       aie0_q,
  input logic [1:0] irq_flag,
  input logic [1:0] alm_hit
);
  assert_ctrl_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_q && wr_i && addr_i == 8'h8F) |=> $stable({hz_q, aie1_q, aie0_q}));

  assert_flag0_needs_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag[0]) |-> $past(tick_i));

  assert_flag1_needs_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag[1]) |-> $past(tick_i));

  assert_hit_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_hit[0] |=> irq_flag[0]);

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !tick_i && addr_i == 8'h07) |=> !irq_flag[0]);

  assert_int0_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aie0_q |-> int0_no);

  assert_int1_from_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int1_o) |-> $past(tick_i));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .tick_i   (tick_i),
  .int0_no  (int0_no),
  .int1_o   (int1_o),
  .wp_q     (wp_q),
  .hz_q     (hz_q),
  .aie1_q   (aie1_q),
  .aie0_q   (aie0_q),
  .irq_flag (irq_flag),
  .alm_hit  (alm_hit)
);

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  localparam int PULSE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [6:0] sec = 7'h01, mnt = 7'h01, hr = 7'h01, dy = 7'h01;
  logic       int0_n, int1, hz_oe;
  int         n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  rtc_alarm_irq #(.PULSE_CYC(PULSE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .sec_i(sec), .min_i(mnt), .hour_i(hr), .day_i(dy),
    .int0_no(int0_n), .int1_o(int1), .hz_oe_o(hz_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 8'h00;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 8'h00;
  endtask

  task automatic do_tick(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h, input logic [6:0] d);
    @(negedge clk); sec = s; mnt = m; hr = h; dy = d; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(8'h10, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(8'h0F, v); chk("R1 ctrl", v, 8'h40);
    chk_status("R1 status", 8'h00);
    chk("R1 int0_no", {7'd0, int0_n}, 8'h01);
    chk("R1 int1_o", {7'd0, int1}, 8'h00);
    chk("R1 hz_oe_o", {7'd0, hz_oe}, 8'h00);
  endtask

  task automatic t_protect;
    logic [7:0] v;
    wr_reg(8'h87, 8'h12);
    rd_reg(8'h07, v); chk("R2 alarm write blocked", v, 8'h00);
    wr_reg(8'h8F, 8'h07);
    rd_reg(8'h0F, v); chk("R2 only protect bit taken", v, 8'h00);
    chk("R2 hz_oe_o unchanged", {7'd0, hz_oe}, 8'h00);
    wr_reg(8'h8F, 8'hFF);
    rd_reg(8'h0F, v); chk("R3 ctrl layout", v, 8'h47);
    chk("R3 hz_oe_o follows bit2", {7'd0, hz_oe}, 8'h01);
    wr_reg(8'h8F, 8'h03);
    rd_reg(8'h0F, v); chk("R2 protected ctrl write", v, 8'h07);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    logic [7:0] vals [8] = '{8'h30, 8'h15, 8'h08, 8'h03, 8'h45, 8'h59, 8'h23, 8'h07};
    for (int i = 0; i < 8; i++) wr_reg(8'h87 + 8'(i), vals[i]);
    for (int i = 0; i < 8; i++) begin
      rd_reg(8'h07 + 8'(i), v);
      chk("R4 readback", v, vals[i]);
    end
  endtask

  task automatic t_compare;
    do_tick(7'h30, 7'h15, 7'h08, 7'h04);
    chk_status("R5 day mismatch", 8'h00);
    @(negedge clk); sec = 7'h30; mnt = 7'h15; hr = 7'h08; dy = 7'h03;
    repeat (3) @(negedge clk);
    chk_status("R5 no tick no compare", 8'h00);
    do_tick(7'h30, 7'h15, 7'h08, 7'h03);
    chk_status("R5 match sets flag0 R7", 8'h01);
    chk("R10 int0 low", {7'd0, int0_n}, 8'h00);
    wr_reg(8'h8F, 8'h06);
    chk("R10 int0 gated off", {7'd0, int0_n}, 8'h01);
    wr_reg(8'h8F, 8'h07);
    chk("R10 int0 low again", {7'd0, int0_n}, 8'h00);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) wr_reg(8'h8B + 8'(i), 8'h80);
    do_tick(7'h30, 7'h15, 7'h08, 7'h03);
    chk_status("R7 both flags", 8'h03);
    wr_reg(8'h8F, 8'h47);
    wr_reg(8'h8C, 8'h11);
    chk_status("R8 rejected write clears flag1 only", 8'h01);
    rd_reg(8'h0C, v); chk("R2 alarm1 unchanged", v, 8'h80);
    wr_reg(8'h8F, 8'h07);
    rd_reg(8'h0F, v); chk("R2 protect cleared", v, 8'h07);
    rd_reg(8'h0A, v); chk("R4 alarm0 day", v, 8'h03);
    chk_status("R8 read clears flag0", 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    do_tick(7'h59, 7'h00, 7'h12, 7'h01);
    chk_status("R6 all masked", 8'h02);
    rd_reg(8'h0B, v);
    wr_reg(8'h8B, 8'h05); wr_reg(8'h8C, 8'h06); wr_reg(8'h8D, 8'h07); wr_reg(8'h8E, 8'h80);
    do_tick(7'h05, 7'h06, 7'h07, 7'h02);
    chk_status("R6 day masked match", 8'h02);
    rd_reg(8'h0E, v);
    do_tick(7'h04, 7'h06, 7'h07, 7'h02);
    chk_status("R6 day masked sec mismatch", 8'h00);
    wr_reg(8'h8C, 8'h80); wr_reg(8'h8D, 8'h80);
    do_tick(7'h05, 7'h33, 7'h22, 7'h06);
    chk_status("R6 seconds only", 8'h02);
    rd_reg(8'h0B, v);
    chk_status("R6 cleared", 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] v;
    @(negedge clk);
    sec = 7'h30; mnt = 7'h15; hr = 7'h08; dy = 7'h03;
    tick = 1'b1; rd = 1'b1; addr = 8'h07;
    @(negedge clk); tick = 1'b0; rd = 1'b0; addr = 8'h00;
    chk_status("R9 set wins over clear", 8'h01);
    rd_reg(8'h07, v);
    chk_status("R9 later clear", 8'h00);
  endtask

  task automatic t_int1;
    int n;
    for (int i = 0; i < 4; i++) wr_reg(8'h8B + 8'(i), 8'h80);
    do_tick(7'h11, 7'h22, 7'h33, 7'h04);
    n = 0;
    while (int1 && n < 100) begin n++; @(negedge clk); end
    chk("R11 pulse length", 8'(n), 8'(PULSE));
    do_tick(7'h11, 7'h22, 7'h33, 7'h04);
    repeat (2) @(negedge clk);
    chk("R11 pulse active", {7'd0, int1}, 8'h01);
    wr_reg(8'h8F, 8'h05);
    chk("R11 enable cleared stops pulse", {7'd0, int1}, 8'h00);
    do_tick(7'h11, 7'h22, 7'h33, 7'h04);
    n = 0;
    for (int i = 0; i < 4; i++) begin n += int1; @(negedge clk); end
    chk("R11 no pulse when disabled", 8'(n), 8'h00);
    chk_status("R11 flag still set", 8'h02);
  endtask

  task automatic t_status_wr;
    wr_reg(8'h90, 8'h00);
    chk_status("R12 write 0x90 ignored", 8'h02);
    wr_reg(8'h10, 8'h01);
    chk_status("R12 write 0x10 ignored", 8'h02);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_protect;
    t_regs;
    t_compare;
    t_clear;
    t_mask;
    t_race;
    t_int1;
    t_status_wr;
    repeat (2) @(negedge clk);
    summary;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    summary;
  end
endmodule